// File: doc/BRIEF.md
# Multi-standard video timing counter

This block produces the horizontal and vertical timing of a colour video camera from a single pixel clock. A two-bit system code selects one of four television systems. Each system fixes the number of clocks in a line and the number of lines in a frame. The block keeps a horizontal clock count and a line count, and decodes from them a horizontal drive pulse, a vertical drive pulse at the start of each field and an interlace field flag.

A companion reset unit can set the horizontal phase with a one-cycle load strobe and a phase value. A falling edge on the vertical reset input sends the line counter back to the top of the frame. A small reference divider runs beside the counters and stands for the divider that feeds a phase loop. Its output pulse stops while the external-sync enable is high. The system code is taken at reset and then only at the end of a frame, so a change never produces a shortened line or frame.

Top module: `vtiming_gen`

## Requirements
- R1: The active system code selects the line length: codes 00 and 10 give 910 clocks and codes 01 and 11 give 908 clocks. `hcount` steps by one per clock from 0 to length-1 and then returns to 0, and the line count advances by one at that return.
- R2: Codes 00 and 10 give 525 lines per frame and codes 01 and 11 give 625. `vcount` returns to 0 after the last line of the frame.
- R3: `sys_mode` is taken on reset and otherwise only at the clock where the last line of a frame ends. A change made during a frame leaves the line length of that frame unchanged.
- R4: `hdrive` is high exactly while `hcount` is below HD_WIDTH (default 64).
- R5: With half = lines/2 (262 or 312), `vdrive` is high on lines 0 to VD_LINES-1 and on lines half to half+VD_LINES-1 (VD_LINES default 9), and low elsewhere.
- R6: `field` is 0 on lines below half and 1 from line half to the last line. It toggles when line half begins and again when the frame returns to line 0.
- R7: A high `h_load` at a clock edge sets `hcount` to `h_phase`, or to 0 when `h_phase` is not below the line length. The line count is left unchanged, and the load takes priority over the end-of-line return.
- R8: A falling edge of `v_rst_in`, sampled with the clock, sets `vcount` to 0 and `field` to 0 on the second clock edge after the input is seen low. A steady level or a rising edge has no effect.
- R9: `ref_pulse` is high for one clock in every REF_DIV clocks (default 8). While `ext_sync` is high the reference divider holds its state, and the line and field counting carries on.
- R10: While `rst_n` is low at a clock edge, `hcount`, `vcount` and `field` are set to 0, the reference divider restarts so that `ref_pulse` is high, and `hdrive` and `vdrive` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_mode | input | 2 | System code: 00, 01, 10, 11 |
| ext_sync | input | 1 | High freezes the reference divider |
| h_load | input | 1 | One-cycle horizontal phase load strobe |
| h_phase | input | HCW | Value loaded into the horizontal count |
| v_rst_in | input | 1 | Vertical reset; acts on its falling edge |
| hcount | output | HCW | Clock position within the line |
| vcount | output | VCW | Line position within the frame |
| hdrive | output | 1 | Horizontal drive pulse |
| vdrive | output | 1 | Vertical drive pulse |
| field | output | 1 | Interlace field flag |
| ref_pulse | output | 1 | Reference divider output pulse |

## Verification
On every cycle the assertions check the following. Both counts stay below the limits of the active system, and the horizontal count steps by one when no load is present. A load lands on the requested phase. The field flag changes only together with the line count. The system code is held between frame ends. The edge detector never fires on two clocks in a row, a detected edge clears the line count and field, and the reference divider is still while the external-sync enable is high. Other behaviour can only be shown by the bench's scenarios. These are the actual lengths of 908, 910, 525 and 625 for each code, the exact lines at which the drive pulses and the field flag change, and a mode change that waits for the end of the frame. They also cover load priority over the line wrap, the two-clock delay of the vertical reset and its one shot per edge, and the pulse period of the divider before and after a freeze.

// File: rtl/vtg_pkg.sv
// Shared definitions for the video timing counter.
// Assumes that the line and frame sizes of the four systems are fixed
// constants; only the selection between them happens at run time.
package vtg_pkg;

    typedef enum logic [1:0] {
        SYS_NTSC  = 2'b00,
        SYS_SECAM = 2'b01,
        SYS_PALM  = 2'b10,
        SYS_PAL   = 2'b11
    } sys_e;

    localparam int LONG_LINE   = 910;
    localparam int SHORT_LINE  = 908;
    localparam int LINES_525   = 525;
    localparam int LINES_625   = 625;

    // Clocks per line for a system code.
    function automatic int line_clocks(sys_e m);
        case (m)
            SYS_NTSC, SYS_PALM: return LONG_LINE;
            default:            return SHORT_LINE;
        endcase
    endfunction

    // Lines per frame for a system code.
    function automatic int frame_lines(sys_e m);
        case (m)
            SYS_NTSC, SYS_PALM: return LINES_525;
            default:            return LINES_625;
        endcase
    endfunction

endpackage

// File: rtl/vtg_hcount.sv
// Horizontal clock counter with phase load and drive pulse decode.
// Assumes h_len changes only at the clock where the count returns to zero.
module vtg_hcount #(
    parameter int HCW      = 10,
    parameter int HD_WIDTH = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HCW-1:0] h_len,
    input  logic           h_load,
    input  logic [HCW-1:0] h_phase,
    output logic [HCW-1:0] hcnt,
    output logic           line_end,
    output logic           hd
);

    localparam logic [HCW-1:0] HD_W = HCW'(HD_WIDTH);

    logic [HCW-1:0] h_last;

    // Last valid position of the current line.
    always_comb h_last = h_len - 1'b1;

    // Count clocks, load the phase on request, wrap at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (h_load) begin
            hcnt <= (h_phase < h_len) ? h_phase : '0;
        end else if (hcnt == h_last) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // End of line only when no load overrides the wrap.
    always_comb line_end = (hcnt == h_last) && !h_load;

    // Drive pulse at the start of each line.
    always_comb hd = (hcnt < HD_W);

    p_hcnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt < h_len);

    p_hcnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_load && hcnt != h_last) |=> hcnt == $past(hcnt) + 1'b1);

    p_hload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_load && h_phase < h_len) |=> hcnt == $past(h_phase));

endmodule

// File: rtl/vtg_vcount.sv
// Line counter, field flag and vertical drive decode.
// Assumes v_total changes only when the frame returns to line zero and
// that v_total is at least 2 * VD_LINES.
module vtg_vcount #(
    parameter int VCW      = 10,
    parameter int VD_LINES = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [VCW-1:0] v_total,
    input  logic           line_end,
    input  logic           v_clear,
    output logic [VCW-1:0] vcnt,
    output logic           field,
    output logic           vd,
    output logic           frame_end
);

    localparam logic [VCW-1:0] VDL = VCW'(VD_LINES);

    logic [VCW-1:0] v_last;
    logic [VCW-1:0] v_half;
    logic [VCW-1:0] v_next;

    // Frame limits derived from the active total.
    always_comb begin
        v_last = v_total - 1'b1;
        v_half = v_total >> 1;
        v_next = vcnt + 1'b1;
    end

    // End of frame: last line finishing without a vertical reset.
    always_comb frame_end = line_end && (vcnt == v_last) && !v_clear;

    // Advance the line count at every line end, clear on vertical reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt <= '0;
        end else if (v_clear) begin
            vcnt <= '0;
        end else if (line_end) begin
            vcnt <= (vcnt == v_last) ? '0 : v_next;
        end
    end

    // Toggle the field at the half-frame line and at the frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field <= 1'b0;
        end else if (v_clear) begin
            field <= 1'b0;
        end else if (line_end && ((vcnt == v_last) || (v_next == v_half))) begin
            field <= ~field;
        end
    end

    // Vertical drive over the first lines of each field.
    always_comb vd = (vcnt < VDL) || ((vcnt >= v_half) && (vcnt < v_half + VDL));

    p_vcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vcnt < v_total);

    p_field_moves_with_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field) |-> !$stable(vcnt));

    p_vclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        v_clear |=> (vcnt == '0) && !field);

endmodule

// File: rtl/vtg_vsync_edge.sv
// Samples the vertical reset input and flags a falling edge for one clock.
// Assumes the input is already synchronous to clk; the idle level is high.
module vtg_vsync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic v_in,
    output logic fall
);

    logic s_now;
    logic s_prev;

    // Two-stage sample of the input level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_now  <= 1'b1;
            s_prev <= 1'b1;
        end else begin
            s_now  <= v_in;
            s_prev <= s_now;
        end
    end

    // High for one clock after a high-to-low change.
    always_comb fall = s_prev && !s_now;

    p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/vtg_refdiv.sv
// Reference divider feeding a phase loop; freezes while hold is high.
// Assumes REF_DIV is at least 2.
module vtg_refdiv #(
    parameter int REF_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic pulse
);

    localparam int RW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam logic [RW-1:0] R_LAST = RW'(REF_DIV - 1);

    logic [RW-1:0] rcnt;

    // Modulo counter, held while external sync is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt <= '0;
        end else if (hold) begin
            rcnt <= rcnt;
        end else if (rcnt == R_LAST) begin
            rcnt <= '0;
        end else begin
            rcnt <= rcnt + 1'b1;
        end
    end

    // One pulse per divider period.
    always_comb pulse = (rcnt == '0);

    p_ref_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(rcnt));

endmodule

// File: rtl/vtiming_gen.sv
// Multi-standard video timing counter: horizontal and line counters sized
// by a two-bit system code, drive pulses, field flag and a freezable
// reference divider. Assumes all inputs are synchronous to clk.
module vtiming_gen #(
    parameter int HCW      = 10,
    parameter int VCW      = 10,
    parameter int HD_WIDTH = 64,
    parameter int VD_LINES = 9,
    parameter int REF_DIV  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     sys_mode,
    input  logic           ext_sync,
    input  logic           h_load,
    input  logic [HCW-1:0] h_phase,
    input  logic           v_rst_in,
    output logic [HCW-1:0] hcount,
    output logic [VCW-1:0] vcount,
    output logic           hdrive,
    output logic           vdrive,
    output logic           field,
    output logic           ref_pulse
);

    import vtg_pkg::*;

    sys_e           mode_act;
    logic [HCW-1:0] h_len;
    logic [VCW-1:0] v_total;
    logic           line_end;
    logic           frame_end;
    logic           v_fall;

    // Adopt the system code on reset and at each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_act <= sys_e'(sys_mode);
        end else if (frame_end) begin
            mode_act <= sys_e'(sys_mode);
        end
    end

    // Geometry of the active system.
    always_comb begin
        h_len   = HCW'(line_clocks(mode_act));
        v_total = VCW'(frame_lines(mode_act));
    end

    vtg_hcount #(
        .HCW      (HCW),
        .HD_WIDTH (HD_WIDTH)
    ) u_h (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_len    (h_len),
        .h_load   (h_load),
        .h_phase  (h_phase),
        .hcnt     (hcount),
        .line_end (line_end),
        .hd       (hdrive)
    );

    vtg_vsync_edge u_ve (
        .clk   (clk),
        .rst_n (rst_n),
        .v_in  (v_rst_in),
        .fall  (v_fall)
    );

    vtg_vcount #(
        .VCW      (VCW),
        .VD_LINES (VD_LINES)
    ) u_v (
        .clk       (clk),
        .rst_n     (rst_n),
        .v_total   (v_total),
        .line_end  (line_end),
        .v_clear   (v_fall),
        .vcnt      (vcount),
        .field     (field),
        .vd        (vdrive),
        .frame_end (frame_end)
    );

    vtg_refdiv #(
        .REF_DIV (REF_DIV)
    ) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (ext_sync),
        .pulse (ref_pulse)
    );

    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(mode_act));

endmodule

// File: tb/vtiming_gen_test.sv
module vtiming_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sys_mode = 2'b00;
    logic       ext_sync = 1'b0;
    logic       h_load = 1'b0;
    logic [9:0] h_phase = '0;
    logic       v_rst_in = 1'b1;
    logic [9:0] hcount;
    logic [9:0] vcount;
    logic       hdrive, vdrive, field, ref_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vtiming_gen uut (
        .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .ext_sync(ext_sync),
        .h_load(h_load), .h_phase(h_phase), .v_rst_in(v_rst_in),
        .hcount(hcount), .vcount(vcount), .hdrive(hdrive), .vdrive(vdrive),
        .field(field), .ref_pulse(ref_pulse)
    );

    typedef struct packed {
        int   cyc;
        int   h;
        int   v;
        logic hd;
        logic rp;
    } vec_t;

    // Cycles after reset release in NTSC: expected hcount, vcount, hdrive, ref_pulse.
    localparam vec_t TBL [7] = '{
        '{1,   1,   0, 1'b1, 1'b0},
        '{8,   8,   0, 1'b1, 1'b1},
        '{63,  63,  0, 1'b1, 1'b0},
        '{64,  64,  0, 1'b0, 1'b1},
        '{909, 909, 0, 1'b0, 1'b0},
        '{910, 0,   1, 1'b1, 1'b0},
        '{912, 2,   1, 1'b1, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Jump to the end of the line, then let it wrap: one line per two clocks.
    task automatic adv_lines(int n, int last);
        for (int i = 0; i < n; i++) begin
            h_load = 1'b1;
            h_phase = 10'(last);
            step();
            h_load = 1'b0;
            step();
        end
    endtask

    task automatic do_reset(logic [1:0] m);
        rst_n = 1'b0;
        sys_mode = m;
        step();
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        int hb;
        bit held;
        // R10 reset state
        sys_mode = 2'b00;
        step(); step(); step();
        chk("R10 hcount", int'(hcount), 0);
        chk("R10 vcount", int'(vcount), 0);
        chk("R10 field", int'(field), 0);
        chk("R10 ref_pulse", int'(ref_pulse), 1);
        chk("R10 hdrive", int'(hdrive), 1);
        chk("R10 vdrive", int'(vdrive), 1);
        rst_n = 1'b1;
        cyc = 0;

        // Vector table: R1 counting, R4 drive, R9 divider period
        for (int k = 0; k < 7; k++) begin
            while (cyc < TBL[k].cyc) begin
                step();
                cyc++;
            end
            chk("R1 hcount table", int'(hcount), TBL[k].h);
            chk("R1 vcount table", int'(vcount), TBL[k].v);
            chk("R4 hdrive table", int'(hdrive), int'(TBL[k].hd));
            chk("R9 ref_pulse table", int'(ref_pulse), int'(TBL[k].rp));
        end

        // R7 phase load, then R1 wrap at 910
        h_load = 1'b1; h_phase = 10'd905; step(); h_load = 1'b0;
        chk("R7 load value", int'(hcount), 905);
        chk("R7 line unchanged", int'(vcount), 1);
        step(); step(); step(); step();
        chk("R1 last clock 909", int'(hcount), 909);
        step();
        chk("R1 wrap hcount", int'(hcount), 0);
        chk("R1 wrap vcount", int'(vcount), 2);

        // R7 out-of-range phase loads zero
        repeat (5) step();
        h_load = 1'b1; h_phase = 10'd1000; step(); h_load = 1'b0;
        chk("R7 out of range", int'(hcount), 0);
        // R7 load beats the wrap
        h_load = 1'b1; h_phase = 10'd909; step();
        h_phase = 10'd100; step(); h_load = 1'b0;
        chk("R7 priority hcount", int'(hcount), 100);
        chk("R7 priority vcount", int'(vcount), 2);

        // R5 and R6 in NTSC
        adv_lines(6, 909);
        chk("R5 line 8 vcount", int'(vcount), 8);
        chk("R5 line 8 vdrive", int'(vdrive), 1);
        adv_lines(1, 909);
        chk("R5 line 9 vdrive", int'(vdrive), 0);
        adv_lines(252, 909);
        chk("R6 line 261 vcount", int'(vcount), 261);
        chk("R6 line 261 field", int'(field), 0);
        chk("R5 line 261 vdrive", int'(vdrive), 0);
        adv_lines(1, 909);
        chk("R6 line 262 field", int'(field), 1);
        chk("R5 line 262 vdrive", int'(vdrive), 1);
        adv_lines(8, 909);
        chk("R5 line 270 vdrive", int'(vdrive), 1);
        adv_lines(1, 909);
        chk("R5 line 271 vdrive", int'(vdrive), 0);

        // R3 mode change mid-frame waits for the frame end
        sys_mode = 2'b11;
        adv_lines(253, 909);
        chk("R2 line 524", int'(vcount), 524);
        h_load = 1'b1; h_phase = 10'd907; step(); h_load = 1'b0;
        step();
        chk("R3 old length kept 908", int'(hcount), 908);
        step();
        chk("R3 old length kept 909", int'(hcount), 909);
        step();
        chk("R2 525 wrap vcount", int'(vcount), 0);
        chk("R6 wrap field", int'(field), 0);
        h_load = 1'b1; h_phase = 10'd907; step(); h_load = 1'b0;
        step();
        chk("R3 new length 908", int'(hcount), 0);
        chk("R1 PAL line advance", int'(vcount), 1);

        // R2, R6 in PAL
        adv_lines(310, 907);
        chk("R6 PAL line 311 field", int'(field), 0);
        adv_lines(1, 907);
        chk("R6 PAL line 312 field", int'(field), 1);
        chk("R5 PAL line 312 vdrive", int'(vdrive), 1);
        adv_lines(312, 907);
        chk("R2 PAL line 624", int'(vcount), 624);
        adv_lines(1, 907);
        chk("R2 625 wrap", int'(vcount), 0);

        // R8 vertical reset
        adv_lines(320, 907);
        chk("R8 pre field", int'(field), 1);
        v_rst_in = 1'b0;
        step();
        chk("R8 not yet", int'(vcount), 320);
        step();
        chk("R8 cleared vcount", int'(vcount), 0);
        chk("R8 cleared field", int'(field), 0);
        adv_lines(3, 907);
        chk("R8 steady low no effect", int'(vcount), 3);
        v_rst_in = 1'b1;
        step(); step(); step();
        chk("R8 rising edge no effect", int'(vcount), 3);

        // R9 divider freeze
        for (int i = 0; i < 8 && !ref_pulse; i++) step();
        chk("R9 pulse found", int'(ref_pulse), 1);
        step();
        chk("R9 pulse one clock", int'(ref_pulse), 0);
        repeat (7) step();
        chk("R9 period", int'(ref_pulse), 1);
        hb = int'(hcount);
        ext_sync = 1'b1;
        held = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            if (!ref_pulse) held = 1'b0;
        end
        chk("R9 held while ext_sync", int'(held), 1);
        chk("R9 counting continues", int'(hcount), (hb + 20) % 908);
        ext_sync = 1'b0;
        step();
        chk("R9 resumes", int'(ref_pulse), 0);
        repeat (7) step();
        chk("R9 period after freeze", int'(ref_pulse), 1);

        // R1, R2, R3 code 01 taken at reset
        do_reset(2'b01);
        h_load = 1'b1; h_phase = 10'd907; step(); h_load = 1'b0;
        step();
        chk("R1 code 01 length 908", int'(hcount), 0);
        adv_lines(623, 907);
        chk("R2 code 01 line 624", int'(vcount), 624);
        adv_lines(1, 907);
        chk("R2 code 01 wrap", int'(vcount), 0);

        // Code 10 taken at reset
        do_reset(2'b10);
        h_load = 1'b1; h_phase = 10'd907; step(); h_load = 1'b0;
        step();
        chk("R1 code 10 length 910", int'(hcount), 908);
        step(); step();
        chk("R1 code 10 wrap", int'(vcount), 1);
        adv_lines(523, 909);
        chk("R2 code 10 line 524", int'(vcount), 524);
        adv_lines(1, 909);
        chk("R2 code 10 wrap", int'(vcount), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule